// File: doc/BRIEF.md
# Programmable Quadrature Waveform Generator

The block drives two square waves, A and B, from one system clock (50 MHz in the intended system), with B trailing A by a quarter of a period. Together they look like the two channels of an incremental quadrature encoder turning at a constant rate. A test fixture or an encoder emulator on an I/O pin is the typical user. The waves are plain flip-flop outputs meant for pins. They never feed a clock network.

A single free-running counter runs through the counts 0 to P-1, where P is the period in system clock cycles. Both phases are decoded from this one counter by comparing it with half, quarter and three-quarter thresholds, so no second clock and no phase-shifting clock resource is needed. The period can be rewritten at any time. The generator takes the new value only at the start of a cycle, so a period change never produces a runt pulse.

Top module: `qgen_quad`

## Requirements
- R1: While `rst` is high at a rising clock edge, `phase_a`, `phase_b` and `wrap` are low after that edge. The first enabled edge after reset starts a fresh cycle at count 0 and raises `wrap`.
- R2: With enable held high, the outputs repeat every P clock cycles, where P is the effective period. The internal count runs 0, 1, ..., P-1 and then returns to 0.
- R3: `phase_a` is high exactly while the count is below P>>1. It therefore rises on the edge that enters count 0 and falls on the edge that enters count P>>1.
- R4: `phase_b` is high exactly while the count is at least P>>2 and below (P>>1)+(P>>2). Any remainder of the shifts is dropped.
- R5: A `period` value below 4 (including 0) is treated as 4, so all four edges fall on distinct counts.
- R6: `period` is sampled only on a reset edge or on the enabled edge where the count returns to 0. Changes at any other time take effect from the next cycle start.
- R7: `wrap` is high for exactly the one clock cycle that follows the edge on which the count returns to 0, and is low at all other times.
- R8: While `en` is low, the count, `phase_a` and `phase_b` keep their values and `wrap` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the waveform |
| period | input | 32 | Cycle length in clock cycles (values below 4 act as 4) |
| phase_a | output | 1 | Leading quadrature phase, registered |
| phase_b | output | 1 | Lagging quadrature phase, registered |
| wrap | output | 1 | One-cycle strobe at each cycle start |

## Verification
The bench sweeps every period from 0 to 16 and one long period, comparing all three outputs on every cycle against an arithmetic model. Odd periods and periods not divisible by four catch a design that rounds the thresholds instead of truncating them, which would place an edge one count off. Periods 0 to 3 catch a missing clamp, which would merge edges or stall the counter. Rewriting the period mid-cycle catches a design that takes it at once, which would cut a pulse short. Irregular enable patterns catch a design that keeps counting or repeats the strobe while frozen.

// File: rtl/qgen_pkg.sv
package qgen_pkg;
  localparam int unsigned QG_PW = 32;

  typedef logic [QG_PW-1:0] cnt_t;

  // Decoded thresholds for one waveform cycle
  typedef struct packed {
    cnt_t last;   // final count before returning to zero
    cnt_t half;   // A falls here
    cnt_t qtr;    // B rises here
    cnt_t three;  // B falls here
  } thr_t;

  function automatic thr_t qg_thresholds(input cnt_t per, input cnt_t floor_v);
    cnt_t p;
    thr_t t;
    p       = (per < floor_v) ? floor_v : per;
    t.last  = p - cnt_t'(1);
    t.half  = p >> 1;
    t.qtr   = p >> 2;
    t.three = t.half + t.qtr;
    return t;
  endfunction
endpackage

// File: rtl/qgen_period.sv
module qgen_period
  import qgen_pkg::*;
#(
  parameter int unsigned MIN_PERIOD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic at_end,
  input  cnt_t period_i,
  output thr_t thr_q,
  output thr_t thr_nx
);
  localparam cnt_t FLOOR = cnt_t'(MIN_PERIOD);

  logic take;
  assign take = rst || (en && at_end);

  always_comb begin
    thr_nx = thr_q;
    if (take) thr_nx = qg_thresholds(period_i, FLOOR);
  end

  always_ff @(posedge clk) begin
    thr_q <= thr_nx;
  end

  // R5: clamped period keeps the four edges strictly ordered
  a_r5_edge_order: assert property (@(posedge clk) disable iff (rst)
    (thr_q.qtr != '0) && (thr_q.qtr < thr_q.half) &&
    (thr_q.half < thr_q.three) && (thr_q.three <= thr_q.last));
endmodule

// File: rtl/qgen_counter.sv
module qgen_counter
  import qgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  thr_t thr_q,
  input  thr_t thr_nx,
  output cnt_t cnt_nx,
  output logic at_end
);
  cnt_t cnt_q;

  assign at_end = (cnt_q == thr_q.last);

  always_comb begin
    if (rst)        cnt_nx = thr_nx.last;  // park at the end: next enabled edge starts at 0
    else if (!en)   cnt_nx = cnt_q;
    else if (at_end) cnt_nx = '0;
    else            cnt_nx = cnt_q + cnt_t'(1);
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nx;
  end

  // R2: count never passes the final value of the current cycle
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= thr_q.last);

  // R8: frozen while disabled
  a_r8_count_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));
endmodule

// File: rtl/qgen_phase.sv
module qgen_phase
  import qgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  cnt_t cnt_nx,
  input  thr_t thr_nx,
  input  logic at_end,
  output logic a_q,
  output logic b_q,
  output logic wrap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      wrap_q <= 1'b0;
    end else if (en) begin
      a_q    <= (cnt_nx < thr_nx.half);
      b_q    <= (cnt_nx >= thr_nx.qtr) && (cnt_nx < thr_nx.three);
      wrap_q <= at_end;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  // R3: A rises only while B is low (count 0)
  a_r3_a_rise_b_low: assert property (@(posedge clk) disable iff (rst)
    $rose(a_q) |-> !b_q);

  // R4: B rises only while A is high (quarter point)
  a_r4_b_rise_a_high: assert property (@(posedge clk) disable iff (rst)
    $rose(b_q) |-> a_q);

  // R7: strobe coincides with cycle start and lasts one cycle
  a_r7_wrap_at_start: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (a_q && !b_q));
  a_r7_wrap_single: assert property (@(posedge clk) disable iff (rst)
    wrap_q |=> !wrap_q);

  // R8: disabled means outputs held, no strobe
  a_r8_outputs_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(a_q) && $stable(b_q) && !wrap_q));
endmodule

// File: rtl/qgen_quad.sv
module qgen_quad
  import qgen_pkg::*;
#(
  parameter int unsigned MIN_PERIOD = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [QG_PW-1:0] period,
  output logic             phase_a,
  output logic             phase_b,
  output logic             wrap
);
  thr_t thr_q;
  thr_t thr_nx;
  cnt_t cnt_nx;
  logic at_end;

  qgen_period #(.MIN_PERIOD(MIN_PERIOD)) u_period (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .at_end   (at_end),
    .period_i (period),
    .thr_q    (thr_q),
    .thr_nx   (thr_nx)
  );

  qgen_counter u_counter (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .thr_q  (thr_q),
    .thr_nx (thr_nx),
    .cnt_nx (cnt_nx),
    .at_end (at_end)
  );

  qgen_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .cnt_nx (cnt_nx),
    .thr_nx (thr_nx),
    .at_end (at_end),
    .a_q    (phase_a),
    .b_q    (phase_b),
    .wrap_q (wrap)
  );
endmodule

// File: tb/qgen_quad_test.sv
`timescale 1ns/1ps
module qgen_quad_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] period = 32'd6;
  logic        phase_a, phase_b, wrap;

  qgen_quad uut (
    .clk(clk), .rst(rst), .en(en), .period(period),
    .phase_a(phase_a), .phase_b(phase_b), .wrap(wrap)
  );

  always #2.5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    m_p   = 4;
  int    m_c   = 3;
  bit    e_a, e_b, e_w;
  bit    live  = 1'b0;
  string tag   = "R1";

  function automatic int eff(input logic [31:0] v);
    return (v < 32'd4) ? 4 : int'(v);
  endfunction

  // Arithmetic model built from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_p = eff(period);
      m_c = m_p - 1;
      e_a = 1'b0; e_b = 1'b0; e_w = 1'b0;
    end else if (en) begin
      if (m_c == m_p - 1) begin
        m_c = 0;
        m_p = eff(period);
        e_w = 1'b1;
      end else begin
        m_c = m_c + 1;
        e_w = 1'b0;
      end
      e_a = (m_c < (m_p >> 1));
      e_b = (m_c >= (m_p >> 2)) && (m_c < ((m_p >> 1) + (m_p >> 2)));
    end else begin
      e_w = 1'b0;
    end
    live = 1'b1;
  end

  task automatic chk(input string what, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("phase_a", phase_a, e_a);
      chk("phase_b", phase_b, e_b);
      chk("wrap",    wrap,    e_w);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    // R1: reset state, then first enabled edge starts a cycle
    tag = "R1";
    run(3);
    rst = 1'b0;
    run(2);
    en = 1'b1;
    run(12);

    // R2/R3/R4/R7: sweep of periods, new value picked at each cycle start
    tag = "R2/R3/R4/R7";
    for (int p = 4; p <= 16; p++) begin
      period = 32'(p);
      run(3 * p);
    end

    // R5: periods below the floor behave as 4
    tag = "R5";
    for (int p = 0; p < 4; p++) begin
      period = 32'(p);
      run(13);
    end

    // R6: mid-cycle rewrites wait for the cycle start
    tag = "R6";
    period = 32'd12;
    run(30);
    for (int k = 0; k < 8; k++) begin
      period = 32'(5 + 3 * k);
      run(3 + k);
    end
    run(40);

    // R8: irregular enable gaps freeze the waveform
    tag = "R8";
    period = 32'd10;
    for (int i = 0; i < 120; i++) begin
      en = ((i % 3) != 0) || ((i % 7) == 0);
      run(1);
    end
    en = 1'b1;
    run(25);

    // R2: one long period
    tag = "R2";
    period = 32'd1000;
    run(2100);

    // R1: reset in the middle of a cycle
    tag = "R1";
    rst = 1'b1;
    period = 32'd7;
    run(2);
    rst = 1'b0;
    run(30);

    finish_up();
  end
endmodule